// File: doc/BRIEF.md
# Flash Write-Status Word Generator

This block forms the word a NOR-style flash returns on a read while an embedded program or erase is running, or while an erase is held in suspension. An embedded-operation controller supplies a busy flag, an operation-type flag and a suspension flag. The address decoder says whether the current read address lies inside the suspended region. The block overrides three bit positions of the array read word: a polling bit, an operation toggle and a region toggle. All other bits pass through from the array.

Host software polls the part by reading repeatedly. The polling bit tells whether a program or erase has finished. The operation toggle flips on every read while anything is running. The region toggle separates a region that is being erased or is suspended from one that is not. Both toggles move only on a read strobe, a one-cycle synchronous pulse. They restart from 0 whenever the busy flag rises. The output is combinational from the inputs and two toggle flip-flops, so a read sees its status word in the same cycle as its strobe. The flips caused by that strobe show from the next cycle on.

Top module: `flash_status_gen`

## Requirements
- R1: With busy low and suspend low, `rd_data` equals `array_word` on all 16 bits.
- R2: With busy high and `op_erase` low (a program), bit 7 of `rd_data` is the complement of `prog_bit7`. Bits other than 7 and 6 come from `array_word`.
- R3: With busy high and `op_erase` high (an erase), bit 7 of `rd_data` is 0. Once busy falls with no suspension, bit 7 follows `array_word` again.
- R4: While busy, bit 6 of `rd_data` inverts in the cycle after each read strobe. It holds through cycles without a strobe.
- R5: During an erase, bit 2 of `rd_data` inverts in the cycle after each read strobe. During a program, bit 2 is `array_word[2]`, and program reads do not advance the region toggle.
- R6: With busy low, suspend high and `addr_in_susp` high, bits 7 and 6 of `rd_data` read 1. Bit 2 inverts in the cycle after each such read strobe. The remaining bits come from `array_word`.
- R7: With busy low, suspend high and `addr_in_susp` low, `rd_data` equals `array_word`. Such a read does not advance the region toggle, which shows on the next in-region read.
- R8: In the cycle where busy rises, bits 6 and 2 of the status read 0, and both toggles count on from that value.
- R9: A program issued while suspend is high behaves as in R2 and R4. Busy takes priority over suspension.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy | input | 1 | Embedded program or erase in progress |
| op_erase | input | 1 | 1 = running operation is an erase, 0 = program |
| susp | input | 1 | An erase is suspended |
| addr_in_susp | input | 1 | Read address lies in the suspended region |
| prog_bit7 | input | 1 | Bit 7 of the word being programmed |
| array_word | input | 16 | Word read from the array |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_data | output | 16 | Status-adjusted read word |

## Verification
The assertions check the fixed overrides on every cycle: pass-through when idle or out of region, the polling bit for program and erase, and the forced ones inside the suspended region. They also check that the operation toggle flips after a strobe, holds without one, and reads 0 when busy rises. Only the bench scenarios can show the toggle history across mode changes. That covers the region toggle surviving out-of-region reads, program reads leaving it untouched, and the restart when a program begins inside a suspension.

// File: rtl/fsts_pkg.sv
// Shared types for the flash write-status generator.
// Assumes: at most one mode is active; the decoder resolves overlaps.
package fsts_pkg;
    typedef enum logic [2:0] {
        MD_IDLE     = 3'd0,
        MD_PROG     = 3'd1,
        MD_ERASE    = 3'd2,
        MD_SUSP_IN  = 3'd3,
        MD_SUSP_OUT = 3'd4
    } stat_mode_t;

    localparam int TG_OP     = 0;   // operation toggle index
    localparam int TG_REGION = 1;   // region toggle index
    localparam int TG_COUNT  = 2;
endpackage

// File: rtl/fsts_mode_decode.sv
// Classifies the controller flags into one status mode and flags the
// cycle in which a new operation starts (busy rising).
// Assumes: busy has priority over suspend; flags are synchronous.
module fsts_mode_decode
    import fsts_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  logic       op_erase,
    input  logic       susp,
    input  logic       addr_in_susp,
    output stat_mode_t mode,
    output logic       op_start
);
    logic busy_q;

    // Remembers last cycle's busy to find the start of an operation.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy;
    end

    assign op_start = busy & ~busy_q;

    // Picks the mode; a running operation outranks a suspension.
    always_comb begin
        if (busy)
            mode = op_erase ? MD_ERASE : MD_PROG;
        else if (susp)
            mode = addr_in_susp ? MD_SUSP_IN : MD_SUSP_OUT;
        else
            mode = MD_IDLE;
    end
endmodule

// File: rtl/fsts_toggle_bank.sv
// A bank of read-driven toggle flip-flops. Each bit shows its current
// value (forced to 0 in a clear cycle) and inverts after an advance.
// Assumes: clear and advance may coincide; clear is applied first.
module fsts_toggle_bank #(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic [NUM-1:0] adv,
    output logic [NUM-1:0] value
);
    for (genvar g = 0; g < NUM; g++) begin : g_tgl
        logic q;

        // Effective value seen by the current read.
        assign value[g] = clear ? 1'b0 : q;

        // Stores the next toggle state after this cycle's read.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= adv[g] ? ~value[g] : value[g];
        end
    end
endmodule

// File: rtl/fsts_word_mux.sv
// Builds the returned word: array data with the polling, operation
// toggle and region toggle positions replaced according to the mode.
// Assumes: bit positions are distinct and inside the data width.
module fsts_word_mux
    import fsts_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int POLL_POS   = 7,
    parameter int OPTGL_POS  = 6,
    parameter int REGTGL_POS = 2
) (
    input  stat_mode_t          mode,
    input  logic [DATA_W-1:0]   array_word,
    input  logic                prog_bit,
    input  logic [TG_COUNT-1:0] tgl,
    output logic [DATA_W-1:0]   rd_data
);
    // Applies the per-mode overrides on top of the array word.
    always_comb begin
        rd_data = array_word;
        unique case (mode)
            MD_PROG: begin
                rd_data[POLL_POS]  = ~prog_bit;
                rd_data[OPTGL_POS] = tgl[TG_OP];
            end
            MD_ERASE: begin
                rd_data[POLL_POS]   = 1'b0;
                rd_data[OPTGL_POS]  = tgl[TG_OP];
                rd_data[REGTGL_POS] = tgl[TG_REGION];
            end
            MD_SUSP_IN: begin
                rd_data[POLL_POS]   = 1'b1;
                rd_data[OPTGL_POS]  = 1'b1;
                rd_data[REGTGL_POS] = tgl[TG_REGION];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/flash_status_gen.sv
// Top of the write-status generator: mode decode, two read-driven
// toggles and the output word mux.
// Assumes: rd_stb is a one-cycle pulse; output is combinational.
module flash_status_gen
    import fsts_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int POLL_POS   = 7,
    parameter int OPTGL_POS  = 6,
    parameter int REGTGL_POS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              op_erase,
    input  logic              susp,
    input  logic              addr_in_susp,
    input  logic              prog_bit7,
    input  logic [DATA_W-1:0] array_word,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data
);
    stat_mode_t          mode;
    logic                op_start;
    logic [TG_COUNT-1:0] adv;
    logic [TG_COUNT-1:0] tgl;

    fsts_mode_decode i_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy         (busy),
        .op_erase     (op_erase),
        .susp         (susp),
        .addr_in_susp (addr_in_susp),
        .mode         (mode),
        .op_start     (op_start)
    );

    // Decides which toggles this read advances.
    always_comb begin
        adv            = '0;
        adv[TG_OP]     = rd_stb & (mode == MD_PROG || mode == MD_ERASE);
        adv[TG_REGION] = rd_stb & (mode == MD_ERASE || mode == MD_SUSP_IN);
    end

    fsts_toggle_bank #(.NUM(TG_COUNT)) i_toggles (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (op_start),
        .adv   (adv),
        .value (tgl)
    );

    fsts_word_mux #(
        .DATA_W     (DATA_W),
        .POLL_POS   (POLL_POS),
        .OPTGL_POS  (OPTGL_POS),
        .REGTGL_POS (REGTGL_POS)
    ) i_mux (
        .mode       (mode),
        .array_word (array_word),
        .prog_bit   (prog_bit7),
        .tgl        (tgl),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/flash_status_gen_chk.sv
// Property checker for flash_status_gen, attached by bind.
// Assumes: default parameter bit positions (7, 6).
module flash_status_gen_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              op_erase,
    input logic              susp,
    input logic              addr_in_susp,
    input logic              prog_bit7,
    input logic [DATA_W-1:0] array_word,
    input logic              rd_stb,
    input logic [DATA_W-1:0] rd_data
);
    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !susp) |-> rd_data == array_word);  // R1
    AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_erase) |-> rd_data[7] == ~prog_bit7);  // R2
    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_erase) |-> rd_data[7] == 1'b0);  // R3
    AST_OPTGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_stb) |=> (!busy || rd_data[6] != $past(rd_data[6])));  // R4
    AST_OPTGL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_stb) |=> (!busy || $stable(rd_data[6])));  // R4
    AST_SUSP_IN_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && susp && addr_in_susp) |-> rd_data[7:6] == 2'b11);  // R6
    AST_SUSP_OUT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && susp && !addr_in_susp) |-> rd_data == array_word);  // R7
    AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy)) |-> rd_data[6] == 1'b0);  // R8
endmodule

bind flash_status_gen flash_status_gen_chk #(.DATA_W(DATA_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .op_erase     (op_erase),
    .susp         (susp),
    .addr_in_susp (addr_in_susp),
    .prog_bit7    (prog_bit7),
    .array_word   (array_word),
    .rd_stb       (rd_stb),
    .rd_data      (rd_data)
);

// File: tb/test_flash_status_gen.sv
module test_flash_status_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        busy = 1'b0, op_erase = 1'b0, susp = 1'b0, addr_in_susp = 1'b0;
    logic        prog_bit7 = 1'b0, rd_stb = 1'b0;
    logic [15:0] array_word = 16'h0000;
    logic [15:0] rd_data;

    int n_chk = 0, n_fail = 0;
    bit m_op = 1'b0, m_reg = 1'b0, m_bprev = 1'b0;   // bench toggle model

    flash_status_gen i_flash_status_gen (.*);

    always #4 clk = ~clk;   // 125 MHz

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Expected word from the requirements.
    function automatic logic [15:0] exp_word(bit b, bit e, bit s, bit a, bit pb,
                                             logic [15:0] arr, bit t_op, bit t_reg);
        logic [15:0] w = arr;
        if (b && !e)      begin w[7] = ~pb; w[6] = t_op; end
        else if (b && e)  begin w[7] = 1'b0; w[6] = t_op; w[2] = t_reg; end
        else if (s && a)  begin w[7] = 1'b1; w[6] = 1'b1; w[2] = t_reg; end
        return w;
    endfunction

    function automatic string tag_of(bit b, bit e, bit s, bit a, bit st);
        if (st)          return "R8 R4";
        if (b && !e)     return s ? "R9 R2 R4 R5" : "R2 R4 R5";
        if (b && e)      return "R3 R4 R5";
        if (s && a)      return "R6";
        if (s)           return "R7";
        return "R1 R3";
    endfunction

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One cycle: drive, check at negedge, advance model at posedge.
    task automatic step(bit b, bit e, bit s, bit a, bit stb, bit pb, logic [15:0] arr);
        bit st, eo, er;
        busy = b; op_erase = e; susp = s; addr_in_susp = a;
        rd_stb = stb; prog_bit7 = pb; array_word = arr;
        st = b && !m_bprev;
        eo = st ? 1'b0 : m_op;
        er = st ? 1'b0 : m_reg;
        @(negedge clk);
        check(tag_of(b, e, s, a, st), rd_data, exp_word(b, e, s, a, pb, arr, eo, er));
        @(posedge clk);
        m_op  = (stb && b) ? ~eo : eo;
        m_reg = (stb && ((b && e) || (!b && s && a))) ? ~er : er;
        m_bprev = b;
        #1;
    endtask

    initial begin
        bit b = 0, e = 0, s = 0, a = 0;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check("R1 reset", rd_data, 16'h0000);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R1 idle pass-through
        step(0, 0, 0, 0, 1, 0, 16'hA5C3);
        step(0, 0, 0, 0, 0, 1, 16'hFFFF);
        // R2/R4/R8 program: strobes and idle cycles
        step(1, 0, 0, 0, 1, 1, 16'h1234);
        step(1, 0, 0, 0, 0, 1, 16'h1234);
        step(1, 0, 0, 0, 1, 1, 16'h1234);
        step(1, 0, 0, 0, 1, 0, 16'h00FF);
        step(0, 0, 0, 0, 1, 0, 16'h00FF);
        // R3/R5 erase, then completion
        step(1, 1, 0, 0, 1, 0, 16'h0000);
        step(1, 1, 0, 0, 1, 0, 16'h0000);
        step(1, 1, 0, 0, 0, 0, 16'h0000);
        step(1, 1, 0, 0, 1, 0, 16'h0000);
        step(0, 0, 0, 0, 0, 0, 16'hFFFF);
        // R6/R7 suspension: in-region, out-of-region, in-region again
        step(0, 1, 1, 1, 1, 0, 16'h0000);
        step(0, 1, 1, 1, 1, 0, 16'h0000);
        step(0, 1, 1, 0, 1, 0, 16'h5A5A);
        step(0, 1, 1, 0, 1, 0, 16'h5A5A);
        step(0, 1, 1, 1, 0, 0, 16'h0000);
        // R9 program while suspended, then back in region
        step(1, 0, 1, 0, 1, 1, 16'h0F0F);
        step(1, 0, 1, 0, 1, 1, 16'h0F0F);
        step(0, 1, 1, 1, 1, 0, 16'h0000);
        step(0, 1, 1, 1, 1, 0, 16'h0000);
        step(0, 0, 0, 0, 0, 0, 16'hC0DE);

        // Random phase with sticky flags.
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(15) == 0) b = ~b;
            if ($urandom_range(15) == 0) e = $urandom_range(1);
            if ($urandom_range(23) == 0) s = ~s;
            if ($urandom_range(3) == 0)  a = $urandom_range(1);
            step(b, e, s, a, $urandom_range(1), $urandom_range(1), 16'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule